// File: doc/BRIEF.md
# Windowed Frame Memory Writer

This block drains 32-bit pixel words from a FIFO and writes each one to external memory over a Wishbone-style master write port. Software sets a window with a base address and a size in bytes. The writer walks the window line by line. Consecutive words in a line occupy consecutive 32-bit locations. At the end of each line, the line base moves forward by a stride. That stride is the normal bytes-per-line value, or a separate virtual bytes-per-line value while zoom is enabled.

Each word is held in a 32-bit swap register before it reaches the data bus. The colour mode, captured together with the word, selects one of three byte orders: full byte reversal for 8-bit pixels, halfword exchange for 16-bit pixels, or no change for 32-bit pixels. A write that would fall outside the window is never issued. Instead, a sticky window-full flag is raised, and the writer stalls until the next frame-start pulse rewinds it to the window base.

Top module: `frame_mem_writer`

## Requirements
- R1: After reset, no bus cycle is started and no word is popped, and `win_full_o` reads 1, even while the FIFO holds data, until `frame_start_i` is pulsed.
- R2: After a frame start, the first available FIFO word starts a bus cycle (`wb_cyc_o` high) in the clock cycle after the word is seen, addressed at `start_addr_i`.
- R3: Word c of a line (c counted from 0, line length `line_words_i` words) is written at the line base plus 4*c.
- R4: With `zoom_en_i` = 0, each new line base is the previous line base plus `bpl_i`.
- R5: With `zoom_en_i` = 1, each new line base is the previous line base plus `vbpl_i`.
- R6: A word whose byte offset o from the window base has o + 4 > `win_size_i` is never written or popped. `win_full_o` goes to 1 and no further writes occur in that frame.
- R7: Mode code 0 (8-bit pixels): bus byte lane i carries byte 3-i of the swap word, which gives a full byte reversal.
- R8: Mode code 1 (16-bit pixels): the bus data is the swap word with its two 16-bit halves exchanged.
- R9: Mode codes 2 and 3 (32-bit pixels): the swap word is driven unchanged.
- R10: During a write, `wb_cyc_o`, `wb_stb_o` and `wb_we_o` are high and `wb_sel_o` is 4'hF. Address and data stay unchanged until `wb_ack_i`, and `fifo_pop_o` pulses once, only in the acknowledge cycle.
- R11: A `frame_start_i` pulse clears `win_full_o` in the next cycle and restarts writing at `start_addr_i` with column and line offset at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start_i | input | 1 | One-cycle pulse that rewinds the writer to the window base |
| mode_i | input | 2 | Colour mode: 0 = 8-bit, 1 = 16-bit, 2/3 = 32-bit |
| zoom_en_i | input | 1 | Selects the virtual line stride |
| start_addr_i | input | AW | Window base byte address |
| win_size_i | input | AW | Window size in bytes |
| line_words_i | input | CW | Words per line |
| bpl_i | input | AW | Line stride in bytes |
| vbpl_i | input | AW | Line stride in bytes used while zoom is on |
| fifo_empty_i | input | 1 | FIFO holds no word |
| fifo_data_i | input | 32 | Word at the FIFO head |
| fifo_pop_o | output | 1 | Removes the head word |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Write enable |
| wb_sel_o | output | 4 | Byte selects |
| wb_adr_o | output | AW | Byte address |
| wb_dat_o | output | 32 | Write data after byte reordering |
| wb_ack_i | input | 1 | Bus acknowledge |
| win_full_o | output | 1 | Sticky flag: the next word would leave the window |

## Verification
The bench sweeps every mode code, both zoom settings and acknowledge latencies of zero to two cycles. Line lengths and strides vary from frame to frame, and each word carries a distinct pattern, so a wrong byte lane, a wrong stride choice or an off-by-one column lands on a mismatched address or value. Most frames use a window that ends one word into the third line, which separates a correct clamp from one that is early or late by a word. Further frames use a window that holds every word, a zero-size window, and a size that is not a multiple of four, which together probe the boundary comparison.

// File: rtl/fmw_pkg.sv
package fmw_pkg;
  typedef enum logic [1:0] {
    PXM_B8   = 2'd0,
    PXM_B16  = 2'd1,
    PXM_B32  = 2'd2,
    PXM_B32X = 2'd3
  } px_mode_e;

  typedef enum logic {
    BS_IDLE = 1'b0,
    BS_XFER = 1'b1
  } bus_st_e;
endpackage

// File: rtl/fmw_swap.sv
module fmw_swap
  import fmw_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic [8*NB-1:0] word_i,
  input  px_mode_e        mode_i,
  output logic [8*NB-1:0] word_o
);
  for (genvar i = 0; i < NB; i++) begin : g_lane
    localparam int SRC_REV  = NB - 1 - i;
    localparam int SRC_HALF = (i + NB / 2) % NB;
    always_comb begin
      unique case (mode_i)
        PXM_B8:  word_o[8*i +: 8] = word_i[8*SRC_REV +: 8];
        PXM_B16: word_o[8*i +: 8] = word_i[8*SRC_HALF +: 8];
        default: word_o[8*i +: 8] = word_i[8*i +: 8];
      endcase
    end
  end
endmodule

// File: rtl/fmw_addr_gen.sv
module fmw_addr_gen #(
  parameter int AW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          advance_i,
  input  logic          check_i,
  input  logic          zoom_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] size_i,
  input  logic [AW-1:0] bpl_i,
  input  logic [AW-1:0] vbpl_i,
  input  logic [CW-1:0] line_words_i,
  output logic [AW-1:0] addr_o,
  output logic          fit_o,
  output logic          full_o
);
  localparam int OW = AW + 2;
  localparam int PW = OW - CW - 2;

  logic [CW-1:0] col_q, col_d;
  logic [AW:0]   loff_q, loff_d;
  logic          full_q, full_d;
  logic          upd_en;
  logic [OW-1:0] cur_off;
  logic [AW-1:0] stride;
  logic          last_col;

  always_comb begin
    stride   = zoom_i ? vbpl_i : bpl_i;
    cur_off  = {1'b0, loff_q} + {{PW{1'b0}}, col_q, 2'b00};
    fit_o    = (cur_off + OW'(4)) <= {2'b00, size_i};
    last_col = (col_q == (line_words_i - CW'(1)));
    addr_o   = start_i + cur_off[AW-1:0];
    full_o   = full_q;
  end

  always_comb begin
    col_d  = col_q;
    loff_d = loff_q;
    full_d = full_q;
    if (restart_i) begin
      col_d  = '0;
      loff_d = '0;
      full_d = 1'b0;
    end else begin
      if (advance_i) begin
        if (last_col) begin
          col_d  = '0;
          loff_d = loff_q + {1'b0, stride};
        end else begin
          col_d = col_q + CW'(1);
        end
      end
      if (check_i && !fit_o) full_d = 1'b1;
    end
  end

  assign upd_en = restart_i | advance_i | (check_i & ~fit_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      loff_q <= '0;
      full_q <= 1'b1;
    end else if (upd_en) begin
      col_q  <= col_d;
      loff_q <= loff_d;
      full_q <= full_d;
    end
  end
endmodule

// File: rtl/fmw_bus_ctrl.sv
module fmw_bus_ctrl
  import fmw_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_empty_i,
  input  logic [31:0]   fifo_data_i,
  input  px_mode_e      mode_i,
  input  logic          fit_i,
  input  logic          full_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ack_i,
  output logic          cyc_o,
  output logic          stb_o,
  output logic          we_o,
  output logic [3:0]    sel_o,
  output logic [AW-1:0] adr_o,
  output logic [31:0]   word_o,
  output px_mode_e      mode_o,
  output logic          pop_o,
  output logic          adv_o,
  output logic          idle_o
);
  bus_st_e       st_q, st_d;
  logic          load_en;
  logic          done;
  logic [AW-1:0] adr_q;
  logic [31:0]   word_q;
  px_mode_e      mode_q;

  always_comb begin
    idle_o  = (st_q == BS_IDLE);
    load_en = idle_o && !full_i && fit_i && !fifo_empty_i;
    done    = (st_q == BS_XFER) && ack_i;
    st_d    = st_q;
    if (load_en)   st_d = BS_XFER;
    else if (done) st_d = BS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BS_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q  <= '0;
      word_q <= '0;
      mode_q <= PXM_B32;
    end else if (load_en) begin
      adr_q  <= addr_i;
      word_q <= fifo_data_i;
      mode_q <= mode_i;
    end
  end

  always_comb begin
    cyc_o  = (st_q == BS_XFER);
    stb_o  = cyc_o;
    we_o   = cyc_o;
    sel_o  = {4{cyc_o}};
    adr_o  = adr_q;
    word_o = word_q;
    mode_o = mode_q;
    pop_o  = done;
    adv_o  = done;
  end
endmodule

// File: rtl/frame_mem_writer.sv
module frame_mem_writer
  import fmw_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_start_i,
  input  logic [1:0]    mode_i,
  input  logic          zoom_en_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [AW-1:0] win_size_i,
  input  logic [CW-1:0] line_words_i,
  input  logic [AW-1:0] bpl_i,
  input  logic [AW-1:0] vbpl_i,
  input  logic          fifo_empty_i,
  input  logic [31:0]   fifo_data_i,
  output logic          fifo_pop_o,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic          wb_we_o,
  output logic [3:0]    wb_sel_o,
  output logic [AW-1:0] wb_adr_o,
  output logic [31:0]   wb_dat_o,
  input  logic          wb_ack_i,
  output logic          win_full_o
);
  logic [1:0]    rsync_q;
  logic          rst_int_n;
  logic [AW-1:0] cur_addr;
  logic          fit, full, adv, idle;
  logic [31:0]   swap_word;
  px_mode_e      held_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  fmw_addr_gen #(.AW(AW), .CW(CW)) u_addr (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .restart_i    (frame_start_i),
    .advance_i    (adv),
    .check_i      (idle),
    .zoom_i       (zoom_en_i),
    .start_i      (start_addr_i),
    .size_i       (win_size_i),
    .bpl_i        (bpl_i),
    .vbpl_i       (vbpl_i),
    .line_words_i (line_words_i),
    .addr_o       (cur_addr),
    .fit_o        (fit),
    .full_o       (full)
  );

  fmw_bus_ctrl #(.AW(AW)) u_bus (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .fifo_empty_i (fifo_empty_i),
    .fifo_data_i  (fifo_data_i),
    .mode_i       (px_mode_e'(mode_i)),
    .fit_i        (fit),
    .full_i       (full),
    .addr_i       (cur_addr),
    .ack_i        (wb_ack_i),
    .cyc_o        (wb_cyc_o),
    .stb_o        (wb_stb_o),
    .we_o         (wb_we_o),
    .sel_o        (wb_sel_o),
    .adr_o        (wb_adr_o),
    .word_o       (swap_word),
    .mode_o       (held_mode),
    .pop_o        (fifo_pop_o),
    .adv_o        (adv),
    .idle_o       (idle)
  );

  fmw_swap #(.NB(4)) u_swap (
    .word_i (swap_word),
    .mode_i (held_mode),
    .word_o (wb_dat_o)
  );

  assign win_full_o = full;
endmodule

// File: rtl/fmw_checker.sv
module fmw_checker #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_start_i,
  input logic [AW-1:0] start_addr_i,
  input logic [AW-1:0] win_size_i,
  input logic          fifo_pop_o,
  input logic          wb_cyc_o,
  input logic          wb_stb_o,
  input logic          wb_we_o,
  input logic [3:0]    wb_sel_o,
  input logic [AW-1:0] wb_adr_o,
  input logic [31:0]   wb_dat_o,
  input logic          wb_ack_i,
  input logic          win_full_o
);
  AST_ADDR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o |-> (wb_adr_o >= start_addr_i) &&
      (({1'b0, wb_adr_o} + (AW+1)'(4)) <= ({1'b0, start_addr_i} + {1'b0, win_size_i}))); // R6

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (win_full_o && !frame_start_i && !wb_cyc_o) |=> !wb_cyc_o); // R6

  AST_STROBE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o |-> (wb_stb_o && wb_we_o && (wb_sel_o == 4'hF))); // R10

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && !wb_ack_i) |=> (wb_cyc_o && $stable(wb_adr_o) && $stable(wb_dat_o))); // R10

  AST_POP_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop_o |-> (wb_cyc_o && wb_ack_i)); // R10

  AST_FRAME_CLEARS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> !win_full_o); // R11
endmodule

bind frame_mem_writer fmw_checker #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .frame_start_i (frame_start_i),
  .start_addr_i  (start_addr_i),
  .win_size_i    (win_size_i),
  .fifo_pop_o    (fifo_pop_o),
  .wb_cyc_o      (wb_cyc_o),
  .wb_stb_o      (wb_stb_o),
  .wb_we_o       (wb_we_o),
  .wb_sel_o      (wb_sel_o),
  .wb_adr_o      (wb_adr_o),
  .wb_dat_o      (wb_dat_o),
  .wb_ack_i      (wb_ack_i),
  .win_full_o    (win_full_o)
);

// File: tb/frame_mem_writer_tb_top.sv
`timescale 1ns/1ps
module frame_mem_writer_tb_top;
  localparam int AW = 16;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          frame_start;
  logic [1:0]    mode;
  logic          zoom;
  logic [AW-1:0] start_addr, win_size, bpl, vbpl;
  logic [CW-1:0] line_words;
  logic          fifo_empty;
  logic [31:0]   fifo_data;
  logic          fifo_pop;
  logic          cyc, stb, we;
  logic [3:0]    sel;
  logic [AW-1:0] adr;
  logic [31:0]   dat;
  logic          ack = 1'b0;
  logic          win_full;

  int checks = 0;
  int fails  = 0;
  logic [31:0] fmem [64];
  int pops = 0;
  int wr   = 0;
  int wcount = 0;
  int wcnt   = 0;
  int e_fr, e_wait, e_w, e_stride, e_start, e_size, e_fit, e_wbase, e_fbase, e_mode, e_zoom;

  always #2.5 clk = ~clk;

  assign fifo_empty = (pops == wr);
  assign fifo_data  = fmem[pops % 64];

  frame_mem_writer #(.AW(AW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start), .mode_i(mode),
    .zoom_en_i(zoom), .start_addr_i(start_addr), .win_size_i(win_size),
    .line_words_i(line_words), .bpl_i(bpl), .vbpl_i(vbpl),
    .fifo_empty_i(fifo_empty), .fifo_data_i(fifo_data), .fifo_pop_o(fifo_pop),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(we), .wb_sel_o(sel),
    .wb_adr_o(adr), .wb_dat_o(dat), .wb_ack_i(ack), .win_full_o(win_full)
  );

  function automatic logic [31:0] pat(int fr, int k);
    return (32'(fr) * 32'h0100_0193 + 32'(k) * 32'h9E37_79B9) ^ 32'h5A5A_C3C3;
  endfunction

  function automatic logic [31:0] swp(logic [31:0] d, int m);
    if (m == 0)      return {d[7:0], d[15:8], d[23:16], d[31:24]};
    else if (m == 1) return {d[15:0], d[31:16]};
    else             return d;
  endfunction

  function automatic int offs(int k, int w, int stride);
    return (k / w) * stride + (k % w) * 4;
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (fifo_pop) pops <= pops + 1;

  // bus responder and per-write checks
  always @(negedge clk) begin
    if (ack) begin
      ack  = 1'b0;
      wcnt = 0;
    end else if (cyc && stb) begin
      if (wcnt >= e_wait) begin
        int k;
        logic [31:0] ed;
        string atag;
        ack = 1'b1;
        k = wcount - e_wbase;
        chk(k < e_fit, "R6 write beyond window", k, e_fit);
        if (k == 0)            atag = "R2";
        else if (k % e_w != 0) atag = "R3";
        else if (e_zoom != 0)  atag = "R5";
        else                   atag = "R4";
        chk(adr == AW'(e_start + offs(k, e_w, e_stride)), atag, adr,
            AW'(e_start + offs(k, e_w, e_stride)));
        ed = swp(pat(e_fr, k), e_mode);
        chk(dat == ed, (e_mode == 0) ? "R7" : (e_mode == 1) ? "R8" : "R9", dat, ed);
        chk(we && sel == 4'hF, "R10 strobe fields", {we, sel}, 5'h1F);
        wcount++;
      end else begin
        wcnt++;
      end
    end
  end

  task automatic run_frame(int fr, int m, int z, int wt, int w, int b, int vb, int sz, int n);
    int guard;
    bit exp_full;
    @(negedge clk);
    mode = 2'(m); zoom = z[0]; line_words = CW'(w);
    bpl = AW'(b); vbpl = AW'(vb); win_size = AW'(sz);
    start_addr = AW'(16'h0400 + fr * 16'h0800);
    e_fr = fr; e_wait = wt; e_w = w; e_stride = z ? vb : b;
    e_start = 16'h0400 + fr * 16'h0800; e_size = sz; e_mode = m; e_zoom = z;
    e_fit = 0;
    for (int k = 0; k < n; k++) begin
      if (offs(k, w, e_stride) + 4 <= sz) e_fit++;
      else break;
    end
    exp_full = (offs(e_fit, w, e_stride) + 4 > sz);
    wr = pops;
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk(win_full == 1'b0, "R11 full cleared", win_full, 0);
    e_wbase = wcount;
    e_fbase = pops;
    for (int i = 0; i < n; i++) fmem[(pops + i) % 64] = pat(fr, i);
    wr = pops + n;
    @(negedge clk);
    if (e_fit > 0) chk(cyc == 1'b1, "R2 write starts", cyc, 1);
    guard = 0;
    while ((wcount - e_wbase) < e_fit && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (6) @(negedge clk);
    chk((wcount - e_wbase) == e_fit, "R6 write count", wcount - e_wbase, e_fit);
    chk((pops - e_fbase) == e_fit, "R10 pop count", pops - e_fbase, e_fit);
    chk(win_full == exp_full, "R6 full flag", win_full, exp_full);
    chk(cyc == 1'b0, "R6 no write after clamp", cyc, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; mode = 2'd0; zoom = 1'b0;
    start_addr = '0; win_size = '0; bpl = '0; vbpl = '0; line_words = CW'(1);
    e_fr = 0; e_wait = 0; e_w = 1; e_stride = 0; e_start = 0; e_size = 0;
    e_fit = 0; e_wbase = 0; e_fbase = 0; e_mode = 0; e_zoom = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(cyc == 1'b0, "R1 no cycle in reset", cyc, 0);
    chk(win_full == 1'b1, "R1 full after reset", win_full, 1);
    start_addr = 16'h0100; win_size = 16'h0100; bpl = 16'h0010; line_words = CW'(2);
    fmem[0] = 32'h1234_5678; fmem[1] = 32'h9ABC_DEF0;
    wr = 2;
    repeat (8) @(negedge clk);
    chk(cyc == 1'b0, "R1 idle before frame start", cyc, 0);
    chk(pops == 0, "R1 nothing popped", pops, 0);
    chk(wcount == 0, "R1 nothing written", wcount, 0);
    chk(win_full == 1'b1, "R1 still full", win_full, 1);
    wr = pops;

    for (int m = 0; m < 4; m++)
      for (int z = 0; z < 2; z++)
        for (int wt = 0; wt < 3; wt++) begin
          int w, b, vb, st;
          w  = 2 + (m + wt) % 3;
          b  = w * 4 + 4 * m;
          vb = b + 12 + 4 * wt;
          st = z ? vb : b;
          run_frame(m * 6 + z * 3 + wt, m, z, wt, w, b, vb, 2 * st + 4 + wt, 12);
        end
    run_frame(24, 0, 1, 1, 3, 16, 40, 16'h0400, 12);
    run_frame(25, 1, 0, 0, 4, 16, 32, 0, 5);
    run_frame(26, 2, 0, 2, 4, 16, 32, 6, 5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule